// File: doc/BRIEF.md
# Daisy-wheel printer strobe sequencer

This block drives a character printer that has no timing logic of its own. A host issues one command at a time: print a character, move the carriage, scroll the paper, restore the printer, or raise or lower the ribbon. For a print or a move, the block samples the printer's active-low status lines through a synchronizer. It aborts with an error flag if the check line reports a fault. Otherwise it waits until the general ready line and the ready line for that operation both read 0.

Once the printer is ready, the block drives the 16-bit control word in three timed phases: the argument alone, then the argument with the matching strobe bit, then the argument alone again. A restore pulses its strobe at once and then waits until all four ready lines read 0. The ribbon bit is a plain level that changes only when the host asks for it. Positions are always relative: a print never moves the carriage or the paper.

Top module: `dwp_strobe_seq`

## Requirements
- R1: While reset is held and right after it is released, ctrl_o is 0, busy_o is 0 and err_o is 0.
- R2: The control word numbers its bits from 0 at the MSB, so word bit n is ctrl_o[15-n]. The bits are laid out as follows: paper strobe at ctrl_o[15], restore at ctrl_o[14], ribbon at ctrl_o[13], daisy (print) strobe at ctrl_o[12], carriage strobe at ctrl_o[11], and the argument in ctrl_o[10:0]. At most one strobe is high at a time.
- R3: Status lines pass through SYNC_STAGES flops. A print (cmd_op_i=0), carriage move (1) or paper move (2) does not start its first phase until the synchronized general ready line and the line for that operation both read 0. Print uses daisy ready, carriage uses carriage ready and paper uses paper ready.
- R4: While a print or move is waiting, check_ni reading 0 takes priority over ready. It sets err_o, ends the command with no strobe, and drops busy_o. err_o then stays at 1 until the next accepted print, move or restore command.
- R5: After the wait, the block runs three phases of exactly PHASE_CYC cycles each: the argument only, then the argument plus the strobe, then the argument only. busy_o is 1 from the cycle after acceptance to the end of the third phase. The argument field stays stable while busy_o is 1.
- R6: For a print, ctrl_o[6:0] carries cmd_arg_i[6:0] and ctrl_o[10:7] are 0.
- R7: For carriage and paper moves, the 11-bit signed displacement passes unchanged to ctrl_o[10:0], covering the full range from -1024 to +1023.
- R8: Restore (cmd_op_i=3) skips the check and ready tests and pulses ctrl_o[14] for PHASE_CYC cycles with a zero argument. busy_o then stays 1 until all four synchronized ready lines read 0.
- R9: Ribbon up (cmd_op_i=4) sets ctrl_o[13] to 1 and ribbon down (5) clears it. The change appears in the cycle after acceptance, with no strobe and without raising busy_o.
- R10: A command offered while busy_o is 1 is ignored. Codes 6 and 7 are also ignored. In both cases ctrl_o and busy_o are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered this cycle; taken only when idle |
| cmd_op_i | input | 3 | Command code: 0 print, 1 carriage, 2 paper, 3 restore, 4 ribbon up, 5 ribbon down |
| cmd_arg_i | input | 11 | Character code (low 7 bits) or signed displacement |
| paper_rdy_ni | input | 1 | Paper ready, active low |
| daisy_rdy_ni | input | 1 | Daisy ready, active low |
| carr_rdy_ni | input | 1 | Carriage ready, active low |
| gen_rdy_ni | input | 1 | General ready, active low |
| check_ni | input | 1 | Printer check, 0 = abnormal |
| ctrl_o | output | 16 | Printer control word, word bit 0 at the MSB |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | Latched check fault |

## Verification
The assertions assume the host offers a command only while the block is idle, or accepts that an offer made while busy is dropped. They also assume the printer status lines change slowly compared with the clock. The stimulus changes each status line at most once every several cycles and drives all inputs half a cycle away from the clock edge. Every status change and every command is issued while the block is idle, or at a known point inside a wait, so the synchronizer delay is the only timing the bench has to model.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  typedef enum logic [2:0] {
    OP_PRINT   = 3'd0,
    OP_CARR    = 3'd1,
    OP_PAPER   = 3'd2,
    OP_RESTORE = 3'd3,
    OP_RIB_UP  = 3'd4,
    OP_RIB_DN  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PH1, S_PH2, S_PH3, S_SETTLE
  } st_e;

  // status bundle bit positions
  localparam int ST_PAPER = 0;
  localparam int ST_DAISY = 1;
  localparam int ST_CARR  = 2;
  localparam int ST_GEN   = 3;
  localparam int ST_CHECK = 4;
  localparam int NUM_ST   = 5;
endpackage

// File: rtl/dwp_sync.sv
module dwp_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dwp_phase_timer.sv
module dwp_phase_timer #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dwp_fsm.sv
module dwp_fsm
  import dwp_pkg::*;
#(
  parameter int ARG_W = 11,
  parameter int CHAR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ARG_W-1:0]  cmd_arg_i,
  input  logic [NUM_ST-1:0] st_n_i,
  input  logic              phase_done_i,
  output logic              phase_run_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              ribbon_o,
  output logic [3:0]        strobe_o,  // {paper, restore, daisy, carriage}
  output logic [ARG_W-1:0]  arg_o
);
  st_e              st_q, st_d;
  op_e              op_q, op_d;
  logic [ARG_W-1:0] arg_q, arg_d;
  logic             err_q, err_d, rib_q, rib_d;
  logic [3:0]       strobe_q, strobe_d;
  logic             op_rdy_n;

  always_comb begin
    case (op_q)
      OP_PRINT: op_rdy_n = st_n_i[ST_DAISY];
      OP_CARR:  op_rdy_n = st_n_i[ST_CARR];
      OP_PAPER: op_rdy_n = st_n_i[ST_PAPER];
      default:  op_rdy_n = 1'b1;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    arg_d = arg_q;
    err_d = err_q;
    rib_d = rib_q;
    case (st_q)
      S_IDLE: begin
        if (cmd_valid_i) begin
          case (cmd_op_i)
            OP_PRINT: begin
              op_d  = OP_PRINT;
              arg_d = ARG_W'(cmd_arg_i[CHAR_W-1:0]);
              err_d = 1'b0;
              st_d  = S_WAIT;
            end
            OP_CARR, OP_PAPER: begin
              op_d  = op_e'(cmd_op_i);
              arg_d = cmd_arg_i;
              err_d = 1'b0;
              st_d  = S_WAIT;
            end
            OP_RESTORE: begin
              op_d  = OP_RESTORE;
              arg_d = '0;
              err_d = 1'b0;
              st_d  = S_PH1;
            end
            OP_RIB_UP: rib_d = 1'b1;
            OP_RIB_DN: rib_d = 1'b0;
            default: ;
          endcase
        end
      end
      S_WAIT: begin
        if (!st_n_i[ST_CHECK]) begin
          err_d = 1'b1;
          st_d  = S_IDLE;
        end else if (!st_n_i[ST_GEN] && !op_rdy_n) begin
          st_d = S_PH1;
        end
      end
      S_PH1: if (phase_done_i) st_d = S_PH2;
      S_PH2: if (phase_done_i) st_d = S_PH3;
      S_PH3: if (phase_done_i) st_d = (op_q == OP_RESTORE) ? S_SETTLE : S_IDLE;
      S_SETTLE: if (st_n_i[ST_GEN:0] == '0) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    strobe_d = '0;
    if (st_d == S_PH2) begin
      case (op_d)
        OP_PAPER:   strobe_d = 4'b1000;
        OP_RESTORE: strobe_d = 4'b0100;
        OP_PRINT:   strobe_d = 4'b0010;
        OP_CARR:    strobe_d = 4'b0001;
        default:    strobe_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      op_q     <= OP_PRINT;
      arg_q    <= '0;
      err_q    <= 1'b0;
      rib_q    <= 1'b0;
      strobe_q <= '0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      arg_q    <= arg_d;
      err_q    <= err_d;
      rib_q    <= rib_d;
      strobe_q <= strobe_d;
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign phase_run_o = (st_q == S_PH1) || (st_q == S_PH2) || (st_q == S_PH3);
  assign err_o       = err_q;
  assign ribbon_o    = rib_q;
  assign strobe_o    = strobe_q;
  assign arg_o       = arg_q;
endmodule

// File: rtl/dwp_strobe_seq.sv
module dwp_strobe_seq
  import dwp_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ARG_W = 11,
  parameter int CHAR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic             paper_rdy_ni,
  input  logic             daisy_rdy_ni,
  input  logic             carr_rdy_ni,
  input  logic             gen_rdy_ni,
  input  logic             check_ni,
  output logic [ARG_W+4:0] ctrl_o,
  output logic             busy_o,
  output logic             err_o
);
  logic [NUM_ST-1:0] st_raw, st_sync;
  logic              run, done, ribbon;
  logic [3:0]        strobe;
  logic [ARG_W-1:0]  arg;

  always_comb begin
    st_raw           = '1;
    st_raw[ST_PAPER] = paper_rdy_ni;
    st_raw[ST_DAISY] = daisy_rdy_ni;
    st_raw[ST_CARR]  = carr_rdy_ni;
    st_raw[ST_GEN]   = gen_rdy_ni;
    st_raw[ST_CHECK] = check_ni;
  end

  dwp_sync #(.WIDTH(NUM_ST), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i, .rst_ni, .d_i(st_raw), .q_o(st_sync)
  );

  dwp_phase_timer #(.CYC(PHASE_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .done_o(done)
  );

  dwp_fsm #(.ARG_W(ARG_W), .CHAR_W(CHAR_W)) u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_arg_i,
    .st_n_i(st_sync), .phase_done_i(done), .phase_run_o(run),
    .busy_o, .err_o, .ribbon_o(ribbon), .strobe_o(strobe), .arg_o(arg)
  );

  // word bit 0 is the MSB
  assign ctrl_o = {strobe[3], strobe[2], ribbon, strobe[1], strobe[0], arg};
endmodule

// File: rtl/dwp_strobe_seq_chk.sv
module dwp_strobe_seq_chk #(
  parameter int ARG_W = 11,
  parameter int CHAR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ARG_W+4:0] ctrl_o,
  input logic             busy_o,
  input logic             err_o
);
  localparam int W = ARG_W + 5;
  logic [3:0] stb;
  assign stb = {ctrl_o[W-1], ctrl_o[W-2], ctrl_o[W-4], ctrl_o[W-5]};

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));
  a_r5_strobe_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb != 4'b0) |-> busy_o);
  a_r5_arg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ctrl_o[ARG_W-1:0]));
  a_r5_strobe_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb != 4'b0) |-> $past(busy_o));
  a_r4_err_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (stb == 4'b0));
  a_r4_err_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
  a_r6_char_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[W-4] |-> (ctrl_o[ARG_W-1:CHAR_W] == '0));
  a_r9_ribbon_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o[W-3]) |-> (!busy_o && !$past(busy_o)));
endmodule

bind dwp_strobe_seq dwp_strobe_seq_chk #(.ARG_W(ARG_W), .CHAR_W(CHAR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_o(ctrl_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/dwp_strobe_seq_tb.sv
module dwp_strobe_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [10:0] cmd_arg = 0;
  logic paper_n = 1, daisy_n = 1, carr_n = 1, gen_n = 1, check_n = 1;
  logic [15:0] ctrl;
  logic busy, err;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dwp_strobe_seq #(.PHASE_CYC(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_arg_i(cmd_arg), .paper_rdy_ni(paper_n), .daisy_rdy_ni(daisy_n),
    .carr_rdy_ni(carr_n), .gen_rdy_ni(gen_n), .check_ni(check_n),
    .ctrl_o(ctrl), .busy_o(busy), .err_o(err)
  );

  // behavioural reference model
  int m_st, m_cnt, m_op;
  logic [10:0] m_arg;
  logic m_err, m_rib;
  logic [4:0] q1, q2;  // {check, gen, carr, daisy, paper}
  logic [15:0] e_ctrl;

  function automatic logic [15:0] exp_word();
    logic ph2;
    ph2 = (m_st == 3);
    return {ph2 && m_op == 2, ph2 && m_op == 3, m_rib, ph2 && m_op == 0, ph2 && m_op == 1, m_arg};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_op = 0; m_arg = 0; m_err = 0; m_rib = 0;
      q1 = '1; q2 = '1;
    end else begin
      case (m_st)
        0: if (cmd_valid) begin
          if (cmd_op == 0) begin m_op = 0; m_arg = {4'b0, cmd_arg[6:0]}; m_err = 0; m_st = 1; end
          else if (cmd_op == 1 || cmd_op == 2) begin m_op = int'(cmd_op); m_arg = cmd_arg; m_err = 0; m_st = 1; end
          else if (cmd_op == 3) begin m_op = 3; m_arg = 0; m_err = 0; m_st = 2; end
          else if (cmd_op == 4) m_rib = 1;
          else if (cmd_op == 5) m_rib = 0;
        end
        1: begin
          if (!q2[4]) begin m_err = 1; m_st = 0; end
          else if (!q2[3] && !q2[(m_op == 0) ? 1 : (m_op == 1) ? 2 : 0]) m_st = 2;
        end
        2, 3, 4: begin
          if (m_cnt == P-1) begin
            m_cnt = 0;
            m_st = (m_st == 4) ? ((m_op == 3) ? 5 : 0) : m_st + 1;
          end else m_cnt++;
        end
        5: if (q2[3:0] == 0) m_st = 0;
        default: m_st = 0;
      endcase
      q2 = q1;
      q1 = {check_n, gen_n, carr_n, daisy_n, paper_n};
    end
    e_ctrl = exp_word();
  end

  // per-clock comparison and strobe counters
  int cnt_pap = 0, cnt_rst = 0, cnt_dai = 0, cnt_car = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (ctrl !== e_ctrl || busy !== (m_st != 0) || err !== m_err) begin
        n_fail++;
        $display("FAIL %s: ctrl=%h busy=%b err=%b expected ctrl=%h busy=%b err=%b",
                 cur_req, ctrl, busy, err, e_ctrl, (m_st != 0), m_err);
      end
      if (ctrl[15]) cnt_pap++;
      if (ctrl[14]) cnt_rst++;
      if (ctrl[12]) cnt_dai++;
      if (ctrl[11]) cnt_car++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [10:0] arg);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c0;
    #(CLK_PERIOD * 3);
    check("R1", int'(ctrl), 0);
    check("R1", int'(busy), 0);
    check("R1", int'(err), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", int'({ctrl, busy, err}), 0);

    // all ready
    paper_n = 0; daisy_n = 0; carr_n = 0; gen_n = 0;
    idle_cycles(4);

    cur_req = "R6";
    c0 = cnt_dai;
    issue(3'd0, 11'h7C1);
    check("R5", int'(busy), 1);
    wait_idle();
    check("R6", int'(ctrl[10:0]), 'h041);
    check("R5", cnt_dai - c0, P);

    cur_req = "R7";
    c0 = cnt_car;
    issue(3'd1, 11'h7FB);  // -5
    wait_idle();
    check("R7", int'(ctrl[10:0]), 'h7FB);
    check("R2", cnt_car - c0, P);
    c0 = cnt_pap;
    issue(3'd2, 11'h3FF);
    wait_idle();
    check("R7", int'(ctrl[10:0]), 'h3FF);
    issue(3'd2, 11'h400);
    wait_idle();
    check("R7", int'(ctrl[10:0]), 'h400);
    check("R2", cnt_pap - c0, 2*P);

    cur_req = "R3";
    daisy_n = 1;
    idle_cycles(4);
    c0 = cnt_dai;
    issue(3'd0, 11'h05A);
    idle_cycles(20);
    check("R3", int'(busy), 1);
    check("R3", cnt_dai - c0, 0);
    gen_n = 1; daisy_n = 0;
    idle_cycles(20);
    check("R3", int'(busy), 1);
    check("R3", cnt_dai - c0, 0);
    gen_n = 0;
    wait_idle();
    check("R3", cnt_dai - c0, P);

    cur_req = "R4";
    check_n = 0;
    idle_cycles(4);
    c0 = cnt_car;
    issue(3'd1, 11'h010);
    idle_cycles(6);
    check("R4", int'(err), 1);
    check("R4", int'(busy), 0);
    check("R4", cnt_car - c0, 0);
    check_n = 1;
    idle_cycles(4);
    issue(3'd2, 11'h020);
    check("R4", int'(err), 0);
    wait_idle();

    cur_req = "R10";
    issue(3'd0, 11'h033);
    issue(3'd1, 11'h111);
    wait_idle();
    check("R10", int'(ctrl[10:0]), 'h033);
    issue(3'd6, 11'h222);
    check("R10", int'(busy), 0);
    check("R10", int'(ctrl), 'h033);

    cur_req = "R9";
    issue(3'd4, 11'h000);
    check("R9", int'(ctrl[13]), 1);
    check("R9", int'(busy), 0);
    issue(3'd0, 11'h041);
    wait_idle();
    check("R9", int'(ctrl[13]), 1);
    issue(3'd5, 11'h000);
    check("R9", int'(ctrl[13]), 0);

    cur_req = "R8";
    paper_n = 1; daisy_n = 1; carr_n = 1; gen_n = 1; check_n = 0;
    idle_cycles(4);
    c0 = cnt_rst;
    issue(3'd3, 11'h155);
    idle_cycles(3*P + 10);
    check("R8", int'(busy), 1);
    check("R8", cnt_rst - c0, P);
    check("R8", int'(ctrl[10:0]), 0);
    paper_n = 0; daisy_n = 0; carr_n = 0; check_n = 1;
    idle_cycles(10);
    check("R8", int'(busy), 1);
    gen_n = 0;
    idle_cycles(6);
    check("R8", int'(busy), 0);
    check("R8", int'(err), 0);

    idle_cycles(5);
    finish_run();
  end
endmodule